// File: doc/BRIEF.md
# Status Flag Condition Evaluator

This block keeps the four arithmetic status flags of a small processor core (negative, zero, carry, overflow) and answers one question per cycle: does the condition attached to the instruction now being issued allow it to execute? The execute stage presents a 4-bit condition code and receives a single pass bit. The pass bit is combinational from the flags currently held.

When an instruction is marked as flag-setting, the execute stage raises an update strobe together with fresh N, Z, C and V values from the ALU. The flag register captures them on the next rising clock edge. Without the strobe the flags hold their value. A synchronous active-high reset clears all four flags.

Top module: `cond_flag_unit`

## Requirements
- R1: After reset all four flags read zero. The flag output is packed as {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R2: When updEn is high at a rising edge, the flag register loads {updN,updZ,updC,updV}. The new value is visible after that edge and not before it.
- R3: When updEn is low at a rising edge, the flags keep their previous value, whatever the updN/updZ/updC/updV inputs are.
- R4: The equality codes use Z. Code 0000 (equal) passes when Z=1. Code 0001 (not equal) passes when Z=0.
- R5: The carry codes use C. Code 0010 (carry set) passes when C=1. Code 0011 (carry clear) passes when C=0.
- R6: The sign codes use N. Code 0100 (minus) passes when N=1. Code 0101 (plus or zero) passes when N=0.
- R7: The overflow codes use V. Code 0110 passes when V=1. Code 0111 passes when V=0.
- R8: The unsigned codes use C and Z. Code 1000 (higher) passes when C=1 and Z=0. Code 1001 (lower or same) passes in every other case.
- R9: The signed codes use N, V and Z. Code 1010 (greater or equal) passes when N equals V, and code 1011 (less than) passes when they differ. Code 1100 (greater than) passes when Z=0 and N equals V, and code 1101 (less or equal) passes otherwise.
- R10: Code 1110 (always) and code 1111 pass for every flag combination.
- R11: The pass bit follows a change of condName within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| condName | input | 4 | Condition code of the issuing instruction |
| updEn | input | 1 | Flag write strobe from a flag-setting instruction |
| updN | input | 1 | New negative flag |
| updZ | input | 1 | New zero flag |
| updC | input | 1 | New carry flag |
| updV | input | 1 | New overflow flag |
| flagsOut | output | 4 | Current flags as {N,Z,C,V} |
| condPass | output | 1 | High when the condition is satisfied |

## Verification
The bench loads all sixteen flag combinations and sweeps every condition code against each one, comparing the result with a reference table written from the pass rules. This catches a swapped complement pair, an inverted carry polarity in the unsigned codes, or a signed test that forgets the zero term.

It also writes with updEn low while driving values that differ from the stored flags. A design that loads regardless of the strobe would show the new values.

Sampling right after the update edge, and before it, exposes a design that makes the update visible too early or one cycle late. Code 1111 is checked separately, because a decoder that treats it as "never" would block every instruction that carries it.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;
  localparam int CODE_W = 4;
  localparam int FLAG_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_XX = 4'hF
  } condCode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic   load;
    flags_t next;
  } flagCtl_t;
endpackage

// File: rtl/cond_flag_ctrl.sv
module cond_flag_ctrl
  import cond_flag_pkg::*;
(
  input  logic     updEn,
  input  logic     updN,
  input  logic     updZ,
  input  logic     updC,
  input  logic     updV,
  output flagCtl_t ctl
);
  always_comb begin
    ctl.load   = updEn;
    ctl.next.n = updN;
    ctl.next.z = updZ;
    ctl.next.c = updC;
    ctl.next.v = updV;
  end
endmodule

// File: rtl/cond_flag_dp.sv
module cond_flag_dp
  import cond_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  flagCtl_t          ctl,
  input  logic [CODE_W-1:0] condName,
  output flags_t            flagsQ,
  output logic              condPass
);
  logic baseHit;
  logic signedEq;

  always_ff @(posedge clk) begin
    if (rst) flagsQ <= '0;
    else if (ctl.load) flagsQ <= ctl.next;
  end

  assign signedEq = (flagsQ.n == flagsQ.v);

  // Even codes name the base test; odd codes below 1110 invert it.
  always_comb begin
    unique case (condName[CODE_W-1:1])
      3'd0: baseHit = flagsQ.z;
      3'd1: baseHit = flagsQ.c;
      3'd2: baseHit = flagsQ.n;
      3'd3: baseHit = flagsQ.v;
      3'd4: baseHit = flagsQ.c & ~flagsQ.z;
      3'd5: baseHit = signedEq;
      3'd6: baseHit = ~flagsQ.z & signedEq;
      default: baseHit = 1'b1;
    endcase
    if (condName[CODE_W-1:1] == 3'd7) condPass = 1'b1;
    else condPass = baseHit ^ condName[0];
  end

  a_r3_hold_flags: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(flagsQ));
  a_r2_load_flags: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (flagsQ == $past(ctl.next)));
  a_r10_always_pass: assert property (@(posedge clk) disable iff (rst)
    (condName == CC_AL || condName == CC_XX) |-> condPass);
  a_r4_eq_pass: assert property (@(posedge clk) disable iff (rst)
    (condName == CC_EQ) |-> (condPass == flagsQ.z));
  a_r8_hi_pass: assert property (@(posedge clk) disable iff (rst)
    (condName == CC_HI) |-> (condPass == (flagsQ.c && !flagsQ.z)));
  a_r9_lt_pass: assert property (@(posedge clk) disable iff (rst)
    (condName == CC_LT) |-> (condPass == (flagsQ.n != flagsQ.v)));
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (flagsQ == '0));
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cond_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] condName,
  input  logic       updEn,
  input  logic       updN,
  input  logic       updZ,
  input  logic       updC,
  input  logic       updV,
  output logic [3:0] flagsOut,
  output logic       condPass
);
  flagCtl_t ctl;
  flags_t   flagsQ;

  cond_flag_ctrl ctrl_i (
    .updEn(updEn), .updN(updN), .updZ(updZ), .updC(updC), .updV(updV),
    .ctl(ctl)
  );

  cond_flag_dp dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .condName(condName),
    .flagsQ(flagsQ), .condPass(condPass)
  );

  assign flagsOut = flagsQ;
endmodule

// File: tb/cond_flag_unit_tb_top.sv
module cond_flag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] condName;
  logic       updEn, updN, updZ, updC, updV;
  logic [3:0] flagsOut;
  logic       condPass;
  int         nTests = 0;
  int         nFail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  cond_flag_unit dut_i (
    .clk(clk), .rst(rst), .condName(condName), .updEn(updEn),
    .updN(updN), .updZ(updZ), .updC(updC), .updV(updV),
    .flagsOut(flagsOut), .condPass(condPass)
  );

  function automatic bit refPass(input logic [3:0] code, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      4'h0: refPass = z;
      4'h1: refPass = !z;
      4'h2: refPass = c;
      4'h3: refPass = !c;
      4'h4: refPass = n;
      4'h5: refPass = !n;
      4'h6: refPass = v;
      4'h7: refPass = !v;
      4'h8: refPass = c && !z;
      4'h9: refPass = !c || z;
      4'hA: refPass = (n == v);
      4'hB: refPass = (n != v);
      4'hC: refPass = !z && (n == v);
      4'hD: refPass = z || (n != v);
      default: refPass = 1'b1;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] code);
    case (code[3:1])
      3'd0: reqOf = "R4";
      3'd1: reqOf = "R5";
      3'd2: reqOf = "R6";
      3'd3: reqOf = "R7";
      3'd4: reqOf = "R8";
      3'd5, 3'd6: reqOf = "R9";
      default: reqOf = "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeFlags(input logic [3:0] f);
    @(negedge clk);
    updEn = 1'b1;
    {updN, updZ, updC, updV} = f;
    @(negedge clk);
    updEn = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1; updEn = 1'b0; condName = 4'h0;
    {updN, updZ, updC, updV} = 4'hF;
    repeat (2) @(negedge clk);
    check("R1 reset flags", flagsOut, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 flags after reset release", flagsOut, 4'h0);
  endtask

  task automatic testLoadTiming();
    @(negedge clk);
    updEn = 1'b1; {updN, updZ, updC, updV} = 4'b1010;
    #1;
    check("R2 not visible before edge", flagsOut, 4'h0);
    @(negedge clk);
    updEn = 1'b0;
    check("R2 visible after edge", flagsOut, 4'b1010);
  endtask

  task automatic testHold();
    writeFlags(4'b0110);
    @(negedge clk);
    updEn = 1'b0; {updN, updZ, updC, updV} = 4'b1001;
    repeat (3) @(negedge clk);
    check("R3 hold without strobe", flagsOut, 4'b0110);
  endtask

  task automatic testSweep();
    for (int f = 0; f < 16; f++) begin
      writeFlags(f[3:0]);
      check("R2 sweep load", flagsOut, f[3:0]);
      for (int k = 0; k < 16; k++) begin
        condName = k[3:0];
        #0.5;
        check(reqOf(k[3:0]), {3'b0, condPass}, {3'b0, refPass(k[3:0], f[3:0])});
      end
    end
  endtask

  task automatic testCombChange();
    writeFlags(4'b0100);
    condName = 4'h0; #0.5;
    check("R11 EQ pass same cycle", {3'b0, condPass}, 4'h1);
    condName = 4'h1; #0.5;
    check("R11 NE fail same cycle", {3'b0, condPass}, 4'h0);
    condName = 4'hF; #0.5;
    check("R10 code 1111 passes", {3'b0, condPass}, 4'h1);
  endtask

  initial begin
    testReset();
    testLoadTiming();
    testHold();
    testSweep();
    testCombChange();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule